// File: doc/BRIEF.md
# 1553 Remote Terminal Command Responder

This block is the command-handling core of a dual-redundant MIL-STD-1553B remote terminal. Two decoders, one per bus channel, deliver 16-bit words. Each word comes with a valid strobe and a sync flag that marks it as a command or as data. The responder picks up commands addressed to this terminal or to the broadcast address. It latches the command fields and counts in the data words that follow on the channel that carried the command. A message ends with a one-cycle status-word transmit request.

The terminal address is strapped on five pins with a sixth pin for odd parity. A bad strap disables the terminal. Each mode code can be made illegal through a 32-bit per-code mask. An illegal command is still answered, with the message error bit set, but its data words are not passed on. The service request, subsystem flag, subsystem error and dynamic-bus-acceptance bits of the reply come from subsystem pins. A broadcast is accepted silently and is reported in the next reply. A valid command that arrives while a message is in progress replaces that message, and the terminal moves to the new command's channel.

Top module: `rt_cmd_responder`

## Requirements
- R1: While `term_sel` is low, no command is accepted: `in_cmd` and `stat_en` are low one cycle later and remain low.
- R2: The strap is valid when `rt_addr` and `rt_par` together hold an odd number of ones. `addr_fault` shows a mismatch one cycle later, and while the strap is invalid no command is accepted.
- R3: A word with `*_valid` and `*_sync` high is a command. The command holds address in [15:11], T/R in [10], subaddress in [9:5] and count/code in [4:0]. It is accepted only when its address equals `rt_addr` or is 11111. On acceptance, `in_cmd`, `cmd_tr`, `cmd_sa` and `cmd_wc` update on the next cycle.
- R4: When both channels present a command in the same cycle, channel A's command is taken. `chan_b` reads 0 for channel A and follows the channel of the accepted command.
- R5: A non-mode receive command (T/R=0) expects `cmd_wc` data words, where 0 means 32. Only valid non-sync words on the active channel count. Each one raises `data_stb` for one cycle with the word on `data_word`. Data words on the other channel are ignored.
- R6: `stat_en` pulses for exactly one cycle. The pulse comes one cycle after the last expected data word, or one cycle after the command when no data word is expected. `in_cmd` stays high through that cycle and falls on the next one.
- R7: The status word holds `rt_addr` in [15:11], message error in [10], `svc_req` in [8], broadcast-received in [4], `ss_flag` in [2], dynamic bus acceptance in [1] and `ss_err` in [0]. All other bits are 0. Pins are sampled in the cycle before `stat_en`.
- R8: Subaddress 00000 or 11111 marks a mode command. A mode command with T/R=0 and code bit 4 set expects one data word. Every other mode command expects none.
- R9: A mode command whose `illegal_mask` bit (indexed by the code) is 1 is illegal. Its reply has message error set, and its data words produce no `data_stb`.
- R10: The dynamic-bus-acceptance bit is 1 only when `dyn_accept` is high and the command is a legal mode command with code 00000.
- R11: A command to address 11111 produces no `stat_en`. The next status reply sent has broadcast-received set, and the reply after that has it clear.
- R12: An accepted command that arrives while a message is in progress aborts that message. The earlier message gets no reply, and the new command and its channel take over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| term_sel | input | 1 | High selects terminal operation |
| rt_addr | input | 5 | Strapped terminal address |
| rt_par | input | 1 | Odd-parity bit for the strap |
| a_valid | input | 1 | Channel A word strobe |
| a_sync | input | 1 | Channel A command sync (1) or data sync (0) |
| a_word | input | 16 | Channel A decoded word |
| b_valid | input | 1 | Channel B word strobe |
| b_sync | input | 1 | Channel B command sync flag |
| b_word | input | 16 | Channel B decoded word |
| illegal_mask | input | 32 | Per-mode-code illegal flags |
| svc_req | input | 1 | Service request status source |
| ss_flag | input | 1 | Subsystem flag status source |
| ss_err | input | 1 | Subsystem error status source |
| dyn_accept | input | 1 | Dynamic bus acceptance source |
| in_cmd | output | 1 | Message sequence in progress |
| chan_b | output | 1 | Active channel, 0 = A |
| cmd_tr | output | 1 | Latched T/R bit |
| cmd_sa | output | 5 | Latched subaddress / mode field |
| cmd_wc | output | 5 | Latched word count / mode code |
| data_stb | output | 1 | Accepted data word strobe |
| data_word | output | 16 | Accepted data word |
| stat_en | output | 1 | Status word transmit request |
| stat_word | output | 16 | Status word reply |
| addr_fault | output | 1 | Strap parity mismatch |

## Verification
The assertions assume that the strapped address does not change inside a message, so that the address in a reply matches the strap one cycle earlier. They also assume the status source pins are stable in the cycle before a reply. The stimulus changes the strap and the status pins only between messages. It changes the parity pin only while the terminal is idle, for the fault case. It draws commands from both channels, with a bias toward mode subaddresses, broadcasts and illegal codes, so the corner cases occur often.

// File: rtl/rt_cmd_pkg.sv
package rt_cmd_pkg;
  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ADDR_W  = 5;
  localparam int unsigned FIELD_W = 5;

  // status bit positions, decoded by the bus controller
  localparam int unsigned SB_ME  = 10;
  localparam int unsigned SB_SR  = 8;
  localparam int unsigned SB_BCR = 4;
  localparam int unsigned SB_SSF = 2;
  localparam int unsigned SB_DBA = 1;
  localparam int unsigned SB_TF  = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_STAT = 2'd2,
    ST_ENDS = 2'd3
  } rt_state_e;
endpackage

// File: rtl/rt_addr_guard.sv
module rt_addr_guard #(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              term_sel,
  input  logic [ADDR_W-1:0] strap,
  input  logic              strap_par,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              par_bad,
  output logic              hit,
  output logic              bcast
);
  localparam logic [ADDR_W-1:0] BCAST_ADDR = '1;

  logic enable;

  always_comb begin
    par_bad = ~(^{strap, strap_par});
    enable  = term_sel & ~par_bad;
    bcast   = (cmd_addr == BCAST_ADDR);
    hit     = enable & ((cmd_addr == strap) | bcast);
  end
endmodule

// File: rtl/rt_chan_pick.sv
module rt_chan_pick #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned N_CH   = 2
) (
  input  logic [N_CH-1:0]   ch_valid,
  input  logic [N_CH-1:0]   ch_sync,
  input  logic [WORD_W-1:0] ch_word [N_CH],
  input  logic              act_ch,
  output logic              cmd_v,
  output logic              cmd_ch,
  output logic [WORD_W-1:0] cmd_w,
  output logic              dat_v,
  output logic [WORD_W-1:0] dat_w
);
  // lowest channel index has priority for commands
  always_comb begin
    cmd_v  = 1'b0;
    cmd_ch = 1'b0;
    cmd_w  = ch_word[0];
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (ch_valid[i] && ch_sync[i]) begin
        cmd_v  = 1'b1;
        cmd_ch = i[0];
        cmd_w  = ch_word[i];
      end
    end
    dat_v = ch_valid[act_ch] & ~ch_sync[act_ch];
    dat_w = ch_word[act_ch];
  end
endmodule

// File: rtl/rt_mode_decode.sv
module rt_mode_decode #(
  parameter int unsigned FIELD_W = 5,
  localparam int unsigned N_CODES = 1 << FIELD_W,
  localparam int unsigned CNT_W   = FIELD_W + 1
) (
  input  logic               tr,
  input  logic [FIELD_W-1:0] sa,
  input  logic [FIELD_W-1:0] wc,
  input  logic [N_CODES-1:0] illegal_mask,
  output logic               is_mode,
  output logic               illegal,
  output logic               dba_ok,
  output logic [CNT_W-1:0]   n_data
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(N_CODES);

  always_comb begin
    is_mode = (sa == '0) || (sa == '1);
    illegal = is_mode & illegal_mask[wc];
    dba_ok  = is_mode & ~illegal & (wc == '0);
    if (is_mode)
      n_data = (!tr && wc[FIELD_W-1]) ? CNT_W'(1) : '0;
    else if (tr)
      n_data = '0;
    else if (wc == '0)
      n_data = FULL_CNT;
    else
      n_data = {1'b0, wc};
  end
endmodule

// File: rtl/rt_cmd_responder.sv
module rt_cmd_responder
  import rt_cmd_pkg::*;
#(
  parameter int unsigned P_WORD_W  = WORD_W,
  parameter int unsigned P_ADDR_W  = ADDR_W,
  parameter int unsigned P_FIELD_W = FIELD_W,
  localparam int unsigned N_CODES  = 1 << P_FIELD_W,
  localparam int unsigned CNT_W    = P_FIELD_W + 1,
  localparam int unsigned ADDR_LSB = P_WORD_W - P_ADDR_W,
  localparam int unsigned TR_BIT   = ADDR_LSB - 1,
  localparam int unsigned SA_LSB   = TR_BIT - P_FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 term_sel,
  input  logic [P_ADDR_W-1:0]  rt_addr,
  input  logic                 rt_par,
  input  logic                 a_valid,
  input  logic                 a_sync,
  input  logic [P_WORD_W-1:0]  a_word,
  input  logic                 b_valid,
  input  logic                 b_sync,
  input  logic [P_WORD_W-1:0]  b_word,
  input  logic [N_CODES-1:0]   illegal_mask,
  input  logic                 svc_req,
  input  logic                 ss_flag,
  input  logic                 ss_err,
  input  logic                 dyn_accept,
  output logic                 in_cmd,
  output logic                 chan_b,
  output logic                 cmd_tr,
  output logic [P_FIELD_W-1:0] cmd_sa,
  output logic [P_FIELD_W-1:0] cmd_wc,
  output logic                 data_stb,
  output logic [P_WORD_W-1:0]  data_word,
  output logic                 stat_en,
  output logic [P_WORD_W-1:0]  stat_word,
  output logic                 addr_fault
);
  logic [P_WORD_W-1:0] ch_word [2];
  logic                cmd_v, cmd_ch, dat_v;
  logic [P_WORD_W-1:0] cmd_w, dat_w;
  logic                par_bad, hit, bcast;
  logic                is_mode, illegal, dba_ok;
  logic [CNT_W-1:0]    n_data;

  rt_state_e        state;
  logic [CNT_W-1:0] remain;
  logic             cur_ill, cur_bc, cur_dba, bc_seen;
  logic             accept;

  assign ch_word[0] = a_word;
  assign ch_word[1] = b_word;

  rt_chan_pick #(.WORD_W(P_WORD_W), .N_CH(2)) u_pick (
    .ch_valid ({b_valid, a_valid}),
    .ch_sync  ({b_sync, a_sync}),
    .ch_word  (ch_word),
    .act_ch   (chan_b),
    .cmd_v    (cmd_v),
    .cmd_ch   (cmd_ch),
    .cmd_w    (cmd_w),
    .dat_v    (dat_v),
    .dat_w    (dat_w)
  );

  rt_addr_guard #(.ADDR_W(P_ADDR_W)) u_guard (
    .term_sel  (term_sel),
    .strap     (rt_addr),
    .strap_par (rt_par),
    .cmd_addr  (cmd_w[P_WORD_W-1:ADDR_LSB]),
    .par_bad   (par_bad),
    .hit       (hit),
    .bcast     (bcast)
  );

  rt_mode_decode #(.FIELD_W(P_FIELD_W)) u_mode (
    .tr           (cmd_w[TR_BIT]),
    .sa           (cmd_w[TR_BIT-1:SA_LSB]),
    .wc           (cmd_w[P_FIELD_W-1:0]),
    .illegal_mask (illegal_mask),
    .is_mode      (is_mode),
    .illegal      (illegal),
    .dba_ok       (dba_ok),
    .n_data       (n_data)
  );

  assign accept = cmd_v & hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      remain     <= '0;
      cur_ill    <= 1'b0;
      cur_bc     <= 1'b0;
      cur_dba    <= 1'b0;
      bc_seen    <= 1'b0;
      in_cmd     <= 1'b0;
      chan_b     <= 1'b0;
      cmd_tr     <= 1'b0;
      cmd_sa     <= '0;
      cmd_wc     <= '0;
      data_stb   <= 1'b0;
      data_word  <= '0;
      stat_en    <= 1'b0;
      stat_word  <= '0;
      addr_fault <= 1'b0;
    end else begin
      stat_en    <= 1'b0;
      data_stb   <= 1'b0;
      addr_fault <= par_bad;
      if (!term_sel) begin
        state  <= ST_IDLE;
        in_cmd <= 1'b0;
      end else if (accept) begin
        // a new command always wins, even over a message in progress
        in_cmd  <= 1'b1;
        chan_b  <= cmd_ch;
        cmd_tr  <= cmd_w[TR_BIT];
        cmd_sa  <= cmd_w[TR_BIT-1:SA_LSB];
        cmd_wc  <= cmd_w[P_FIELD_W-1:0];
        cur_ill <= illegal;
        cur_bc  <= bcast;
        cur_dba <= dba_ok;
        remain  <= n_data;
        if (bcast) bc_seen <= 1'b1;
        state   <= (n_data != '0) ? ST_DATA : ST_STAT;
      end else begin
        unique case (state)
          ST_DATA: begin
            if (dat_v) begin
              data_stb  <= ~cur_ill;
              data_word <= dat_w;
              remain    <= remain - 1'b1;
              if (remain == CNT_W'(1)) state <= ST_STAT;
            end
          end
          ST_STAT: begin
            if (!cur_bc) begin
              stat_en   <= 1'b1;
              stat_word <= '0;
              stat_word[P_WORD_W-1:ADDR_LSB] <= rt_addr;
              stat_word[SB_ME]  <= cur_ill;
              stat_word[SB_SR]  <= svc_req;
              stat_word[SB_BCR] <= bc_seen;
              stat_word[SB_SSF] <= ss_flag;
              stat_word[SB_DBA] <= cur_dba & dyn_accept;
              stat_word[SB_TF]  <= ss_err;
              bc_seen <= 1'b0;
            end
            state <= ST_ENDS;
          end
          ST_ENDS: begin
            in_cmd <= 1'b0;
            state  <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rt_cmd_responder_chk.sv
module rt_cmd_responder_chk (
  input logic        clk,
  input logic        rst,
  input logic        term_sel,
  input logic [4:0]  rt_addr,
  input logic        rt_par,
  input logic        dyn_accept,
  input logic        in_cmd,
  input logic        data_stb,
  input logic        stat_en,
  input logic [15:0] stat_word
);
  a_r1_off_stays_idle: assert property (@(posedge clk) disable iff (rst)
    !term_sel |=> (!in_cmd && !stat_en));

  a_r2_bad_strap_no_start: assert property (@(posedge clk) disable iff (rst)
    (^{rt_addr, rt_par} == 1'b0) |=> !$rose(in_cmd));

  a_r6_reply_inside_msg: assert property (@(posedge clk) disable iff (rst)
    stat_en |-> in_cmd);

  a_r6_reply_one_cycle: assert property (@(posedge clk) disable iff (rst)
    stat_en |=> !stat_en);

  a_r5_data_inside_msg: assert property (@(posedge clk) disable iff (rst)
    data_stb |-> in_cmd);

  a_r7_reply_addr: assert property (@(posedge clk) disable iff (rst)
    stat_en |-> (stat_word[15:11] == $past(rt_addr)));

  a_r10_dba_from_pin: assert property (@(posedge clk) disable iff (rst)
    (stat_en && stat_word[1]) |-> $past(dyn_accept));

  a_r9_illegal_no_dba: assert property (@(posedge clk) disable iff (rst)
    (stat_en && stat_word[10]) |-> !stat_word[1]);
endmodule

bind rt_cmd_responder rt_cmd_responder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .term_sel   (term_sel),
  .rt_addr    (rt_addr),
  .rt_par     (rt_par),
  .dyn_accept (dyn_accept),
  .in_cmd     (in_cmd),
  .data_stb   (data_stb),
  .stat_en    (stat_en),
  .stat_word  (stat_word)
);

// File: tb/rt_cmd_responder_bench.sv
module rt_cmd_responder_bench;
  localparam logic [4:0] MY = 5'd9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic term_sel = 1'b1;
  logic [4:0] rt_addr = MY;
  logic rt_par = ~(^MY);
  logic a_valid = 0, a_sync = 0, b_valid = 0, b_sync = 0;
  logic [15:0] a_word = '0, b_word = '0;
  logic [31:0] illegal_mask = '0;
  logic svc_req = 0, ss_flag = 0, ss_err = 0, dyn_accept = 0;
  logic in_cmd, chan_b, cmd_tr, data_stb, stat_en, addr_fault;
  logic [4:0] cmd_sa, cmd_wc;
  logic [15:0] data_word, stat_word;

  int n_chk = 0, n_fail = 0;
  bit bc_pend = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rt_cmd_responder u_rt_cmd_responder (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input bit ch, input bit sync, input logic [15:0] w);
    if (ch) begin b_valid = 1; b_sync = sync; b_word = w; end
    else    begin a_valid = 1; a_sync = sync; a_word = w; end
    @(negedge clk);
    a_valid = 0; b_valid = 0;
  endtask

  function automatic logic [15:0] mk(input logic [4:0] ad, input logic tr,
                                     input logic [4:0] sa, input logic [4:0] wc);
    return {ad, tr, sa, wc};
  endfunction

  function automatic int unsigned ndata(input logic tr, input logic [4:0] sa, input logic [4:0] wc);
    if (sa == 0 || sa == 31) return (!tr && wc[4]) ? 1 : 0;
    if (tr) return 0;
    return (wc == 0) ? 32 : wc;
  endfunction

  function automatic logic [15:0] exp_stat(input bit ill, input bit bcp, input bit dba);
    return {MY, ill, 1'b0, svc_req, 3'b000, bcp, 1'b0, ss_flag, dba, ss_err};
  endfunction

  task automatic run_msg(input bit ch, input logic tr, input logic [4:0] sa,
                         input logic [4:0] wc, input bit bc);
    bit mode, ill, dba;
    int unsigned nd;
    logic [15:0] d;
    mode = (sa == 0 || sa == 31);
    ill  = mode && illegal_mask[wc];
    dba  = mode && !ill && wc == 0 && dyn_accept;
    nd   = ndata(tr, sa, wc);
    send(ch, 1, mk(bc ? 5'd31 : MY, tr, sa, wc));
    chk("R3 in_cmd after command", in_cmd, 1);
    chk("R3 latched fields", {cmd_tr, cmd_sa, cmd_wc}, {tr, sa, wc});
    chk("R4 active channel", chan_b, ch);
    for (int i = 0; i < nd; i++) begin
      d = 16'($urandom());
      send(ch, 0, d);
      chk("R9 R5 data strobe", data_stb, !ill);
      if (!ill) chk("R5 data word", data_word, d);
    end
    chk("R6 no reply before status cycle", stat_en, 0);
    @(negedge clk);
    chk("R11 R6 reply request", stat_en, !bc);
    if (!bc) begin
      chk("R7 R10 status word", stat_word, exp_stat(ill, bc_pend, dba));
      bc_pend = 0;
    end else begin
      bc_pend = 1;
    end
    chk("R6 in_cmd during reply", in_cmd, 1);
    @(negedge clk);
    chk("R6 in_cmd falls", in_cmd, 0);
    chk("R6 reply one cycle", stat_en, 0);
  endtask

  initial begin
    void'($urandom(32'd1553));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R6 reset in_cmd", in_cmd, 0);
    chk("R6 reset stat_en", stat_en, 0);
    chk("R4 reset chan_b", chan_b, 0);
    chk("R2 reset addr_fault", addr_fault, 0);

    // R1: terminal operation not selected
    term_sel = 0;
    send(0, 1, mk(MY, 1, 5'd2, 5'd3));
    chk("R1 no accept when deselected", in_cmd, 0);
    @(negedge clk);
    chk("R1 no reply when deselected", stat_en, 0);
    term_sel = 1;

    // R3: other address ignored
    send(1, 1, mk(5'd5, 1, 5'd2, 5'd3));
    chk("R3 foreign address ignored", in_cmd, 0);

    // R2: bad parity
    rt_par = ~rt_par;
    @(negedge clk);
    chk("R2 fault flagged", addr_fault, 1);
    send(0, 1, mk(MY, 1, 5'd2, 5'd3));
    chk("R2 no accept on bad strap", in_cmd, 0);
    rt_par = ~rt_par;
    @(negedge clk);
    chk("R2 fault cleared", addr_fault, 0);

    // R4: simultaneous commands, A wins
    a_valid = 1; a_sync = 1; a_word = mk(MY, 1, 5'd4, 5'd6);
    b_valid = 1; b_sync = 1; b_word = mk(MY, 1, 5'd4, 5'd7);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    chk("R4 channel A priority", chan_b, 0);
    chk("R4 channel A fields", cmd_wc, 6);
    @(negedge clk);
    chk("R6 reply after transmit command", stat_en, 1);
    @(negedge clk);

    // R5: data on the other channel ignored
    send(1, 1, mk(MY, 0, 5'd3, 5'd2));
    send(0, 0, 16'h1234);
    chk("R5 other-channel data ignored", data_stb, 0);
    send(1, 0, 16'hAAAA);
    chk("R5 first word", data_word, 16'hAAAA);
    send(1, 0, 16'h5555);
    @(negedge clk);
    chk("R5 reply after two words", stat_en, 1);
    chk("R7 plain status", stat_word, exp_stat(0, 0, 0));
    @(negedge clk);

    // R12: abort on other channel
    send(0, 1, mk(MY, 0, 5'd6, 5'd3));
    send(0, 0, 16'h0101);
    send(1, 1, mk(MY, 1, 5'd3, 5'd4));
    chk("R12 channel switched", chan_b, 1);
    chk("R12 new fields", {cmd_tr, cmd_wc}, {1'b1, 5'd4});
    chk("R12 no reply for aborted", stat_en, 0);
    @(negedge clk);
    chk("R12 reply for new command", stat_en, 1);
    @(negedge clk);
    chk("R12 message ends", in_cmd, 0);

    // R10 / R9: dynamic bus control legal and illegal
    dyn_accept = 1;
    illegal_mask = 32'h0;
    run_msg(0, 1, 5'd0, 5'd0, 0);
    illegal_mask = 32'h1;
    run_msg(1, 1, 5'd31, 5'd0, 0);
    // R10: non-mode command never sets the bit
    illegal_mask = 32'h0;
    run_msg(0, 1, 5'd7, 5'd0, 0);
    dyn_accept = 0;
    // R8: mode code 17 receive takes one word, transmit none
    run_msg(0, 0, 5'd0, 5'd17, 0);
    run_msg(1, 1, 5'd0, 5'd17, 0);
    // R9: illegal mode with data word
    illegal_mask = 32'h0002_0000;
    run_msg(0, 0, 5'd31, 5'd17, 0);
    illegal_mask = 32'h0;
    // R11: broadcast then two replies
    run_msg(0, 0, 5'd2, 5'd2, 1);
    run_msg(0, 1, 5'd2, 5'd1, 0);
    run_msg(1, 1, 5'd2, 5'd1, 0);
    // R5: word count 0 means 32
    run_msg(1, 0, 5'd9, 5'd0, 0);

    // random mix
    for (int m = 0; m < 60; m++) begin
      logic [4:0] sa, wc;
      logic tr;
      bit ch, bc;
      int unsigned pick;
      illegal_mask = $urandom() & $urandom();
      svc_req = 1'($urandom()); ss_flag = 1'($urandom());
      ss_err = 1'($urandom()); dyn_accept = 1'($urandom());
      pick = $urandom_range(0, 3);
      sa = (pick == 0) ? 5'd0 : (pick == 1) ? 5'd31 : 5'($urandom_range(1, 30));
      wc = 5'($urandom());
      tr = 1'($urandom());
      ch = 1'($urandom());
      bc = ($urandom_range(0, 7) == 0);
      run_msg(ch, tr, sa, wc, bc);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule